// File: doc/BRIEF.md
# Scalar Operand Source Decoder

This block takes the 9-bit source-operand field of a GPU-style instruction and sorts it into one of six kinds. These are a general scalar register, a special register whose value lives in the wave state and not in the scalar file, an inline constant, a literal that follows the instruction word, a vector register, or an illegal code. When the field names an inline constant, the block produces the 32-bit value itself, so no register read is needed downstream. Integer constants, used for example as memory offsets, appear on one output. Single-precision floating-point constants appear on a second output and raise their own flag.

The result is registered once. A valid bit and an instruction tag travel with it, so the decoded operand stays aligned with its instruction in the pipeline. Register files, literal fetch and execution units sit outside this block.

Top module: `opnd_src_decode`

## Requirements
- R1: A field with bit 8 set asserts the vector flag, and the index output equals field bits 7:0.
- R2: Field values 0 up to NUM_SGPR-1 (default 103) assert the general flag, and the index output equals the field value.
- R3: Values 106 and 107 assert the special flag with out_spec_exec=0 (VCC). Values 126 and 127 assert it with out_spec_exec=1 (EXEC). out_spec_hi equals field bit 0.
- R4: Value 128 asserts the constant flag with integer value 0. The general flag stays low.
- R5: Values 129 to 192 assert the constant flag with integer value field-128, which gives 1 to 64.
- R6: Values 193 to 208 assert the constant flag with integer value 192-field, which gives -1 to -16, sign-extended to 32 bits.
- R7: Values 240 to 247 assert the constant flag and out_fp. out_fp_val carries 0.5, -0.5, 1.0, -1.0, 2.0, -2.0, 4.0, -4.0 in IEEE-754 single precision, in that order, and out_int_val is 0.
- R8: Value 255 asserts the literal flag.
- R9: Every remaining value with bit 8 clear asserts the illegal flag. These are NUM_SGPR..105, 108..125, 209..239 and 248..254.
- R10: While out_valid is high, exactly one of the six kind flags is high. While out_valid is low, all six are low.
- R11: Outputs appear one clock after the input is sampled, together with its valid bit and tag. A synchronous active-low reset clears out_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input field is valid |
| in_tag | input | TAG_W | Instruction tag carried alongside |
| in_field | input | 9 | Source-operand field |
| out_valid | output | 1 | Registered valid |
| out_tag | output | TAG_W | Registered tag |
| out_sgpr | output | 1 | General scalar register |
| out_special | output | 1 | Special register from wave state |
| out_const | output | 1 | Inline constant |
| out_literal | output | 1 | Literal follows instruction |
| out_vgpr | output | 1 | Vector register |
| out_illegal | output | 1 | Unassigned code |
| out_idx | output | 8 | Register index for general or vector kinds, else 0 |
| out_spec_exec | output | 1 | Special selects EXEC (1) or VCC (0) |
| out_spec_hi | output | 1 | Special selects the high half |
| out_fp | output | 1 | Constant is floating point |
| out_int_val | output | 32 | Integer constant value |
| out_fp_val | output | 32 | Floating-point constant value |

## Verification
The bench builds the block with its defaults: NUM_SGPR=104 and TAG_W=4. With these values, all 512 field codes can be swept, so every kind boundary is reached, including the edges at 103/104, 192/193 and 208/209. The 4-bit tag is wide enough to tell neighbouring instructions apart during back-to-back issue.

// File: rtl/opnd_src_pkg.sv
// Shared kinds and code points for the operand source decoder.
// Assumes a 9-bit operand field; the code points below fix the decoding map.
package opnd_src_pkg;
    typedef enum logic [2:0] {
        KIND_SGPR,
        KIND_SPECIAL,
        KIND_CONST,
        KIND_LITERAL,
        KIND_VGPR,
        KIND_ILLEGAL
    } src_kind_e;

    localparam int FIELD_W = 9;
    localparam logic [8:0] CODE_VCC_LO   = 9'd106;
    localparam logic [8:0] CODE_VCC_HI   = 9'd107;
    localparam logic [8:0] CODE_EXEC_LO  = 9'd126;
    localparam logic [8:0] CODE_EXEC_HI  = 9'd127;
    localparam logic [8:0] CODE_ZERO     = 9'd128;
    localparam logic [8:0] CODE_POS_LAST = 9'd192;
    localparam logic [8:0] CODE_NEG_LAST = 9'd208;
    localparam logic [8:0] CODE_FP_FIRST = 9'd240;
    localparam logic [8:0] CODE_FP_LAST  = 9'd247;
    localparam logic [8:0] CODE_LITERAL  = 9'd255;
endpackage

// File: rtl/opnd_classify.sv
// Classifies a 9-bit operand field into a source kind and, for special
// registers, which one and which half. Purely combinational.
// Assumes NUM_SGPR <= 106 so general registers never overlap VCC.
module opnd_classify
    import opnd_src_pkg::*;
#(
    parameter int NUM_SGPR = 104
) (
    input  logic [FIELD_W-1:0] field,
    output src_kind_e          kind,
    output logic               spec_exec,
    output logic               spec_hi
);
    localparam logic [8:0] SGPR_END = 9'(NUM_SGPR);

    // Decide the kind of operand from the code point ranges.
    always_comb begin
        spec_exec = 1'b0;
        spec_hi   = field[0];
        if (field[8]) begin
            kind = KIND_VGPR;
        end else if (field < SGPR_END) begin
            kind = KIND_SGPR;
        end else if (field == CODE_VCC_LO || field == CODE_VCC_HI) begin
            kind = KIND_SPECIAL;
        end else if (field == CODE_EXEC_LO || field == CODE_EXEC_HI) begin
            kind      = KIND_SPECIAL;
            spec_exec = 1'b1;
        end else if (field >= CODE_ZERO && field <= CODE_NEG_LAST) begin
            kind = KIND_CONST;
        end else if (field >= CODE_FP_FIRST && field <= CODE_FP_LAST) begin
            kind = KIND_CONST;
        end else if (field == CODE_LITERAL) begin
            kind = KIND_LITERAL;
        end else begin
            kind = KIND_ILLEGAL;
        end
    end
endmodule

// File: rtl/opnd_const_gen.sv
// Computes the inline constant value for a field: integer constants on
// int_val, single-precision constants on fp_val. Values are zero outside
// their ranges. Assumes the classifier decides whether the result is used.
module opnd_const_gen
    import opnd_src_pkg::*;
(
    input  logic [FIELD_W-1:0] field,
    output logic [31:0]        int_val,
    output logic [31:0]        fp_val,
    output logic               fp_hit
);
    logic [31:0] wide;
    logic [7:0]  fp_exp;

    assign wide   = {23'b0, field};
    assign fp_exp = 8'd126 + {6'b0, field[2:1]};

    // Integer constant: counts up from the zero code, then down below zero.
    always_comb begin
        if (field >= CODE_ZERO && field <= CODE_POS_LAST)
            int_val = wide - {23'b0, CODE_ZERO};
        else if (field > CODE_POS_LAST && field <= CODE_NEG_LAST)
            int_val = {23'b0, CODE_POS_LAST} - wide;
        else
            int_val = 32'd0;
    end

    // Float constant: bit 0 gives the sign, bits 2:1 step the exponent from 0.5.
    always_comb begin
        fp_hit = (field >= CODE_FP_FIRST) && (field <= CODE_FP_LAST);
        fp_val = fp_hit ? {field[0], fp_exp, 23'b0} : 32'd0;
    end
endmodule

// File: rtl/opnd_src_decode.sv
// Top of the operand source decoder: classifies the field, produces inline
// constant values and registers the result with valid and tag, one cycle
// after the input. Flags are zero whenever the output is not valid.
module opnd_src_decode
    import opnd_src_pkg::*;
#(
    parameter int NUM_SGPR = 104,
    parameter int TAG_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [TAG_W-1:0] in_tag,
    input  logic [8:0]       in_field,
    output logic             out_valid,
    output logic [TAG_W-1:0] out_tag,
    output logic             out_sgpr,
    output logic             out_special,
    output logic             out_const,
    output logic             out_literal,
    output logic             out_vgpr,
    output logic             out_illegal,
    output logic [7:0]       out_idx,
    output logic             out_spec_exec,
    output logic             out_spec_hi,
    output logic             out_fp,
    output logic [31:0]      out_int_val,
    output logic [31:0]      out_fp_val
);
    src_kind_e   kind;
    logic        spec_exec, spec_hi, fp_hit;
    logic [31:0] int_val, fp_val;

    opnd_classify #(.NUM_SGPR(NUM_SGPR)) u_classify (
        .field     (in_field),
        .kind      (kind),
        .spec_exec (spec_exec),
        .spec_hi   (spec_hi)
    );

    opnd_const_gen u_const (
        .field   (in_field),
        .int_val (int_val),
        .fp_val  (fp_val),
        .fp_hit  (fp_hit)
    );

    // Pipeline stage: capture the decoded operand alongside valid and tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            out_tag       <= '0;
            out_sgpr      <= 1'b0;
            out_special   <= 1'b0;
            out_const     <= 1'b0;
            out_literal   <= 1'b0;
            out_vgpr      <= 1'b0;
            out_illegal   <= 1'b0;
            out_idx       <= '0;
            out_spec_exec <= 1'b0;
            out_spec_hi   <= 1'b0;
            out_fp        <= 1'b0;
            out_int_val   <= '0;
            out_fp_val    <= '0;
        end else begin
            out_valid     <= in_valid;
            out_tag       <= in_tag;
            out_sgpr      <= in_valid && kind == KIND_SGPR;
            out_special   <= in_valid && kind == KIND_SPECIAL;
            out_const     <= in_valid && kind == KIND_CONST;
            out_literal   <= in_valid && kind == KIND_LITERAL;
            out_vgpr      <= in_valid && kind == KIND_VGPR;
            out_illegal   <= in_valid && kind == KIND_ILLEGAL;
            out_idx       <= (in_valid && (kind == KIND_SGPR || kind == KIND_VGPR))
                             ? in_field[7:0] : 8'd0;
            out_spec_exec <= in_valid && kind == KIND_SPECIAL && spec_exec;
            out_spec_hi   <= in_valid && kind == KIND_SPECIAL && spec_hi;
            out_fp        <= in_valid && fp_hit;
            out_int_val   <= in_valid ? int_val : 32'd0;
            out_fp_val    <= in_valid ? fp_val : 32'd0;
        end
    end

    // Assertions guarding the stage.
    assert_vgpr_index_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && in_valid && in_field[8]) |-> out_vgpr && out_idx == $past(in_field[7:0]));
    assert_vcc_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && in_valid && in_field == CODE_VCC_HI) |-> out_special && !out_spec_exec && out_spec_hi);
    assert_zero_not_sgpr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && in_valid && in_field == CODE_ZERO) |-> out_const && !out_sgpr && out_int_val == 32'd0);
    assert_fp_int_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_fp |-> out_const && out_int_val == 32'd0 && out_fp_val[22:0] == 23'd0);
    assert_one_kind_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $countones({out_sgpr, out_special, out_const, out_literal, out_vgpr, out_illegal}) == 1);
    assert_no_kind_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $countones({out_sgpr, out_special, out_const, out_literal, out_vgpr, out_illegal}) == 0);
    assert_valid_tag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> out_valid == $past(in_valid) && out_tag == $past(in_tag));
endmodule

// File: tb/opnd_src_decode_bench.sv
// Directed bench for the operand source decoder: one task per scenario.
module opnd_src_decode_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TAG_W = 4;
    localparam int WATCHDOG = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [TAG_W-1:0] in_tag = '0;
    logic [8:0] in_field = '0;
    logic out_valid, out_sgpr, out_special, out_const, out_literal, out_vgpr, out_illegal;
    logic out_spec_exec, out_spec_hi, out_fp;
    logic [TAG_W-1:0] out_tag;
    logic [7:0] out_idx;
    logic [31:0] out_int_val, out_fp_val;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    opnd_src_decode #(.NUM_SGPR(104), .TAG_W(TAG_W)) u_opnd_src_decode (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tag(in_tag), .in_field(in_field),
        .out_valid(out_valid), .out_tag(out_tag), .out_sgpr(out_sgpr), .out_special(out_special),
        .out_const(out_const), .out_literal(out_literal), .out_vgpr(out_vgpr),
        .out_illegal(out_illegal), .out_idx(out_idx), .out_spec_exec(out_spec_exec),
        .out_spec_hi(out_spec_hi), .out_fp(out_fp), .out_int_val(out_int_val),
        .out_fp_val(out_fp_val)
    );

    // Kind flags packed as {sgpr, special, const, literal, vgpr, illegal}.
    function automatic logic [5:0] kinds();
        return {out_sgpr, out_special, out_const, out_literal, out_vgpr, out_illegal};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Present one field; returns after the registered result is visible.
    task automatic issue(input logic [8:0] f, input logic [TAG_W-1:0] t);
        @(negedge clk);
        in_valid = 1'b1;
        in_field = f;
        in_tag = t;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R11 reset valid", {31'b0, out_valid}, 32'd0);
        chk("R10 reset kinds", {26'b0, kinds()}, 32'd0);
    endtask

    task automatic t_vector();
        issue(9'h100, 4'd1);
        chk("R1 vgpr 0", {26'b0, kinds()}, 32'b000010);
        chk("R1 idx 0", {24'b0, out_idx}, 32'd0);
        issue(9'h1FF, 4'd2);
        chk("R1 vgpr 255", {26'b0, kinds()}, 32'b000010);
        chk("R1 idx 255", {24'b0, out_idx}, 32'd255);
    endtask

    task automatic t_general();
        issue(9'd0, 4'd3);
        chk("R2 s0", {26'b0, kinds()}, 32'b100000);
        issue(9'd103, 4'd4);
        chk("R2 s103", {26'b0, kinds()}, 32'b100000);
        chk("R2 idx 103", {24'b0, out_idx}, 32'd103);
    endtask

    task automatic t_special();
        issue(9'd106, 4'd5);
        chk("R3 vcc lo", {26'b0, kinds(), out_spec_exec, out_spec_hi}, {26'b0, 6'b010000, 2'b00} >> 0);
        issue(9'd107, 4'd6);
        chk("R3 vcc hi", {30'b0, out_spec_exec, out_spec_hi}, 32'b01);
        issue(9'd126, 4'd7);
        chk("R3 exec lo", {30'b0, out_spec_exec, out_spec_hi}, 32'b10);
        chk("R3 exec kind", {26'b0, kinds()}, 32'b010000);
        issue(9'd127, 4'd8);
        chk("R3 exec hi", {30'b0, out_spec_exec, out_spec_hi}, 32'b11);
    endtask

    task automatic t_zero();
        issue(9'h080, 4'd9);
        chk("R4 zero kind", {26'b0, kinds()}, 32'b001000);
        chk("R4 zero value", out_int_val, 32'd0);
    endtask

    task automatic t_ints();
        for (int v = 129; v <= 192; v++) begin
            issue(9'(v), 4'(v));
            chk("R5 pos kind", {26'b0, kinds()}, 32'b001000);
            chk("R5 pos value", out_int_val, 32'(v - 128));
        end
        for (int v = 193; v <= 208; v++) begin
            issue(9'(v), 4'(v));
            chk("R6 neg kind", {26'b0, kinds()}, 32'b001000);
            chk("R6 neg value", out_int_val, 32'(192 - v));
        end
    endtask

    task automatic t_float();
        logic [31:0] exp_fp [8] = '{32'h3F000000, 32'hBF000000, 32'h3F800000, 32'hBF800000,
                                    32'h40000000, 32'hC0000000, 32'h40800000, 32'hC0800000};
        for (int k = 0; k < 8; k++) begin
            issue(9'(240 + k), 4'(k));
            chk("R7 fp kind", {25'b0, kinds(), out_fp}, 32'b0010001);
            chk("R7 fp value", out_fp_val, exp_fp[k]);
            chk("R7 int zero", out_int_val, 32'd0);
        end
    endtask

    task automatic t_literal();
        issue(9'd255, 4'd10);
        chk("R8 literal", {26'b0, kinds()}, 32'b000100);
    endtask

    task automatic t_illegal();
        for (int v = 0; v < 256; v++) begin
            if ((v >= 104 && v <= 105) || (v >= 108 && v <= 125) ||
                (v >= 209 && v <= 239) || (v >= 248 && v <= 254)) begin
                issue(9'(v), 4'(v));
                chk("R9 illegal", {26'b0, kinds()}, 32'b000001);
            end
        end
    endtask

    task automatic t_onehot_sweep();
        for (int v = 0; v < 512; v++) begin
            issue(9'(v), 4'(v));
            chk("R10 one kind", $countones(kinds()), 32'd1);
        end
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk("R10 idle kinds", {26'b0, kinds()}, 32'd0);
    endtask

    task automatic t_pipeline();
        issue(9'd5, 4'hA);
        chk("R11 valid", {31'b0, out_valid}, 32'd1);
        chk("R11 tag A", {28'b0, out_tag}, 32'hA);
        issue(9'h080, 4'h3);
        chk("R11 tag 3", {28'b0, out_tag}, 32'h3);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk("R11 drop valid", {31'b0, out_valid}, 32'd0);
        @(negedge clk);
        in_valid = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        chk("R11 reset clears", {31'b0, out_valid}, 32'd0);
        rst_n = 1'b1;
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_vector();
        t_general();
        t_special();
        t_zero();
        t_ints();
        t_float();
        t_literal();
        t_illegal();
        t_onehot_sweep();
        t_pipeline();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule